// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a parallel flash device. It decides when an embedded program or erase operation inside the device has finished. A one-cycle start pulse hands it the address of the bank being polled. The block then runs read cycles over a request/acknowledge port and drives the device chip-select, output-enable and write-enable strobes. It watches one status bit that flips on every read while the device is busy. When two consecutive reads return the same value of that bit, the operation is complete. A second status bit flags that the device has run past its internal time limit. Once that flag is seen, two confirmation reads settle the outcome.

A local cap on the number of toggling comparisons stops the search if completion never shows. Every failing outcome first sends a reset command word to the device, so the array is readable again, and only then reports failure. The caller sees `busy` for the whole search and then a single-cycle `done` or `fail`.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: While reset is applied and after its release, `busy`, `done`, `fail`, `rd_req` and `wr_req` are 0 and `cs_n`, `oe_n` and `we_n` are 1.
- R2: `start` is accepted only when idle, and it latches `poll_addr` onto `dev_addr`. `busy` is 1 from the cycle after the accepted start up to the cycle in which `done` or `fail` is 1, and in that cycle `busy` is 0. A `start` while busy has no effect on `dev_addr` or on the sequence of reads.
- R3: During a read, `cs_n` and `oe_n` are 0 while `rd_req` is held until `rd_ack`. Between any two reads, `oe_n` returns to 1, so there is one falling edge of `oe_n` per read. `dev_addr` changes only when `oe_n` is 1 in that cycle and in the previous one.
- R4: Status bit 6 (TOG_BIT) of the first two reads is compared. If it is equal, `done` pulses after exactly 2 reads and no write is made.
- R5: If bit 6 differs and bit 5 (ERR_BIT) of the newer read is 0, one more read is made and compared with the newest earlier read. The search ends with `done` after exactly (number of toggling reads + 2) reads.
- R6: If bit 6 differs and bit 5 of the newer read is 1, exactly two more reads follow and are compared with each other. If they differ, the fail path is taken. If they are equal, `done` pulses.
- R7: The MAX_POLLS-th toggling comparison with bit 5 at 0 takes the fail path after 1+MAX_POLLS reads. MAX_POLLS-1 toggles followed by a steady read end in `done`. When bit 5 is 1 at that same comparison, the confirmation reads of R6 take precedence.
- R8: The fail path makes exactly one write of RESET_CMD (0xF0) with `cs_n` and `we_n` at 0 and `oe_n` at 1. `fail` pulses in the cycle after `wr_ack`.
- R9: `done` and `fail` are single-cycle pulses and are never 1 together.
- R10: A `start` given in the same cycle as a `done` or `fail` pulse is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin polling |
| poll_addr | input | AW | Bank/status address to poll |
| busy | output | 1 | Polling in progress |
| done | output | 1 | One-cycle pulse: operation completed |
| fail | output | 1 | One-cycle pulse: operation failed or limit reached |
| rd_req | output | 1 | Status read request, held until acknowledged |
| rd_ack | input | 1 | Read acknowledge, qualifies `rd_data` |
| rd_data | input | DW | Status word from the device |
| wr_req | output | 1 | Reset-command write request, held until acknowledged |
| wr_ack | input | 1 | Write acknowledge |
| wr_data | output | DW | Reset command word |
| dev_addr | output | AW | Address driven to the device |
| cs_n | output | 1 | Device chip-select, active low |
| oe_n | output | 1 | Device output-enable, active low |
| we_n | output | 1 | Device write-enable, active low |

## Verification
Two things can land in one cycle: the end of a search (the `done` or `fail` pulse, with `busy` dropping) and the acceptance of a new `start`. The bench watches for a `done` pulse and drives `start` with a fresh address in that very cycle. It then requires `busy` to be high and the new address on `dev_addr` one cycle later, followed by a complete second search. A second coincidence is the limit count and the timeout flag arriving at the same comparison. The bench judges it by read count: 3+MAX_POLLS reads means the confirmation path took priority, and 1+MAX_POLLS reads would mean the limit won.

// File: rtl/tgp_pkg.sv
package tgp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_READ,
    ST_GAP,
    ST_RSTCMD
  } st_t;

  typedef enum logic [1:0] {
    RK_FIRST,
    RK_POLL,
    RK_CONF1,
    RK_CONF2
  } rk_t;

  // A toggle bit moved between two reads.
  function automatic logic bit_flipped(input logic older, input logic newer);
    return older ^ newer;
  endfunction

  // True when one more increment would make the count reach the limit.
  function automatic logic reaches_limit(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction

endpackage

// File: rtl/tgp_status_cmp.sv
module tgp_status_cmp #(
  parameter int unsigned DW      = 8,
  parameter int unsigned TOG_BIT = 6,
  parameter int unsigned ERR_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [DW-1:0] data,
  input  logic          load_prev,
  output logic          toggled,
  output logic          err_flag
);
  logic [DW-1:0] cur_word;
  logic          prev_tog;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_word <= '0;
      prev_tog <= 1'b0;
    end else begin
      if (capture)   cur_word <= data;
      if (load_prev) prev_tog <= cur_word[TOG_BIT];
    end
  end

  assign toggled  = tgp_pkg::bit_flipped(prev_tog, cur_word[TOG_BIT]);
  assign err_flag = cur_word[ERR_BIT];

  // R5: the word under comparison is the one the last acknowledged read brought
  a_r5_capture_word: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> cur_word == $past(data));

endmodule

// File: rtl/tgp_poll_cnt.sv
module tgp_poll_cnt #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last_step
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign last_step = tgp_pkg::reaches_limit(int'(cnt), LIMIT);

  // R7: the count of toggling comparisons never passes the cap
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !last_step);

endmodule

// File: rtl/tgp_strobes.sv
module tgp_strobes (
  input  tgp_pkg::st_t st,
  output logic         cs_n,
  output logic         oe_n,
  output logic         we_n,
  output logic         rd_req,
  output logic         wr_req
);
  import tgp_pkg::*;

  assign rd_req = (st == ST_READ);
  assign wr_req = (st == ST_RSTCMD);
  assign oe_n   = !rd_req;
  assign we_n   = !wr_req;
  assign cs_n   = !(rd_req || wr_req);

  // R8: output-enable and write-enable are never active together
  always_comb begin
    a_r8_oe_we_excl: assert ($onehot0({!oe_n, !we_n}));
  end

endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl #(
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 8,
  parameter int unsigned TOG_BIT   = 6,
  parameter int unsigned ERR_BIT   = 5,
  parameter int unsigned MAX_POLLS = 16,
  parameter int unsigned RESET_CMD = 'hF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] poll_addr,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic          rd_req,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          wr_req,
  input  logic          wr_ack,
  output logic [DW-1:0] wr_data,
  output logic [AW-1:0] dev_addr,
  output logic          cs_n,
  output logic          oe_n,
  output logic          we_n
);
  import tgp_pkg::*;

  st_t  st, st_nxt;
  rk_t  kind, kind_nxt;
  logic [AW-1:0] addr_q;
  logic done_q, fail_q;

  // named internal events
  logic take_start, capture, load_prev, cnt_clr, cnt_inc;
  logic toggled, err_flag, last_step;
  logic ev_complete, ev_confirm, ev_limit, ev_go_on, ev_conf_bad;
  logic done_set, fail_enter;

  tgp_status_cmp #(.DW(DW), .TOG_BIT(TOG_BIT), .ERR_BIT(ERR_BIT)) cmp_i (
    .clk(clk), .rst_n(rst_n), .capture(capture), .data(rd_data),
    .load_prev(load_prev), .toggled(toggled), .err_flag(err_flag));

  tgp_poll_cnt #(.LIMIT(MAX_POLLS)) cnt_i (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .last_step(last_step));

  tgp_strobes strb_i (
    .st(st), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .rd_req(rd_req), .wr_req(wr_req));

  assign take_start = (st == ST_IDLE) && start;
  assign capture    = (st == ST_READ) && rd_ack;

  // decisions taken in the gap cycle after a read
  assign ev_complete = (st == ST_GAP) && (kind == RK_POLL) && !toggled;
  assign ev_confirm  = (st == ST_GAP) && (kind == RK_POLL) && toggled && err_flag;
  assign ev_limit    = (st == ST_GAP) && (kind == RK_POLL) && toggled && !err_flag && last_step;
  assign ev_go_on    = (st == ST_GAP) && (kind == RK_POLL) && toggled && !err_flag && !last_step;
  assign ev_conf_bad = (st == ST_GAP) && (kind == RK_CONF2) && toggled;

  assign done_set   = ev_complete || ((st == ST_GAP) && (kind == RK_CONF2) && !toggled);
  assign fail_enter = ev_limit || ev_conf_bad;
  assign cnt_clr    = take_start;
  assign cnt_inc    = ev_go_on;
  assign load_prev  = (st == ST_GAP) &&
                      ((kind == RK_FIRST) || (kind == RK_CONF1) || ev_confirm || ev_go_on);

  always_comb begin
    st_nxt   = st;
    kind_nxt = kind;
    unique case (st)
      ST_IDLE: if (start) begin
        st_nxt   = ST_ARM;
        kind_nxt = RK_FIRST;
      end
      ST_ARM:  st_nxt = ST_READ;
      ST_READ: if (rd_ack) st_nxt = ST_GAP;
      ST_GAP: begin
        if (done_set)        st_nxt = ST_IDLE;
        else if (fail_enter) st_nxt = ST_RSTCMD;
        else                 st_nxt = ST_READ;
        unique case (kind)
          RK_FIRST: kind_nxt = RK_POLL;
          RK_POLL:  if (ev_confirm) kind_nxt = RK_CONF1;
          RK_CONF1: kind_nxt = RK_CONF2;
          RK_CONF2: kind_nxt = RK_CONF2;
          default:  kind_nxt = RK_FIRST;
        endcase
      end
      ST_RSTCMD: if (wr_ack) st_nxt = ST_IDLE;
      default:   st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      kind   <= RK_FIRST;
      addr_q <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st     <= st_nxt;
      kind   <= kind_nxt;
      done_q <= done_set;
      fail_q <= (st == ST_RSTCMD) && wr_ack;
      if (take_start) addr_q <= poll_addr;
    end
  end

  assign busy     = (st != ST_IDLE);
  assign done     = done_q;
  assign fail     = fail_q;
  assign dev_addr = addr_q;
  assign wr_data  = DW'(RESET_CMD);

  // R9: outcomes are exclusive and last one cycle
  a_r9_excl: assert property (@(posedge clk) disable iff (!rst_n) !(done && fail));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r9_fail_pulse: assert property (@(posedge clk) disable iff (!rst_n) fail |=> !fail);
  // R2: busy is low in the outcome cycle and only drops there
  a_r2_busy_end: assert property (@(posedge clk) disable iff (!rst_n) (done || fail) |-> !busy);
  a_r2_busy_fall: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (done || fail));
  // R3: address moves only with output-enable released before and after
  a_r3_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dev_addr) |-> (oe_n && $past(oe_n)));
  a_r3_gap_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ack) |=> (oe_n && cs_n));
  // R8: a failure is always preceded by the acknowledged reset write
  a_r8_fail_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> $past(wr_ack && wr_req));

endmodule

// File: tb/toggle_poll_ctrl_tb_top.sv
module toggle_poll_ctrl_tb_top;
  localparam int AW = 16, DW = 8, MAXP = 16, LAT = 2;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] poll_addr = '0;
  logic busy, done, fail, rd_req, wr_req, cs_n, oe_n, we_n;
  logic rd_ack = 0, wr_ack = 0;
  logic [DW-1:0] rd_data = '0, wr_data;
  logic [AW-1:0] dev_addr;

  int total = 0, bad = 0, cycles = 0;
  int toggles_left = 0, err_from = 1000000, rd_cnt = 0, wr_cnt = 0, lat_cnt = 0;
  int oe_falls = 0, addr_viol = 0, wr_strobe_bad = 0;
  logic t6 = 0, prev_oe = 1;
  logic [AW-1:0] prev_addr = '0;
  logic [DW-1:0] last_wr = '0;

  always #2.5 clk = ~clk;

  toggle_poll_ctrl #(.AW(AW), .DW(DW), .MAX_POLLS(MAXP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .poll_addr(poll_addr), .busy(busy),
    .done(done), .fail(fail), .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data),
    .wr_req(wr_req), .wr_ack(wr_ack), .wr_data(wr_data), .dev_addr(dev_addr),
    .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n));

  // device model: status bit 6 flips after each read while toggles remain,
  // bit 5 is set from read index err_from onward
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      rd_ack <= 0; wr_ack <= 0; lat_cnt <= 0;
    end else begin
      if (rd_ack) rd_ack <= 0;
      else if (wr_ack) wr_ack <= 0;
      else if (rd_req || wr_req) begin
        if (lat_cnt == LAT) begin
          lat_cnt <= 0;
          if (rd_req) begin
            rd_ack  <= 1;
            rd_data <= {1'b0, t6, (rd_cnt >= err_from), 5'b0};
            rd_cnt  <= rd_cnt + 1;
            if (toggles_left > 0) begin t6 <= ~t6; toggles_left <= toggles_left - 1; end
          end else begin
            wr_ack  <= 1;
            last_wr <= wr_data;
            wr_cnt  <= wr_cnt + 1;
            if (cs_n || we_n || !oe_n) wr_strobe_bad <= wr_strobe_bad + 1;
          end
        end else lat_cnt <= lat_cnt + 1;
      end
      if (prev_oe && !oe_n) oe_falls <= oe_falls + 1;
      if (rd_req && (cs_n || oe_n)) addr_viol <= addr_viol + 1;
      if ((dev_addr != prev_addr) && !(oe_n && prev_oe)) addr_viol <= addr_viol + 1;
      prev_oe   <= oe_n;
      prev_addr <= dev_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input int tog, input int errf);
    @(negedge clk);
    toggles_left = tog; err_from = errf; rd_cnt = 0; wr_cnt = 0; oe_falls = 0;
  endtask

  task automatic kick(input logic [AW-1:0] a);
    start = 1; poll_addr = a;
    @(negedge clk);
    start = 0;
    chk(busy === 1'b1, "R2 busy after start", busy, 1);
  endtask

  // returns 1 for done, 2 for fail, 0 on timeout; leaves time at the outcome negedge
  task automatic wait_end(output int res);
    res = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done || fail) begin
        res = done ? 1 : 2;
        if (done && fail) res = 3;
        break;
      end
    end
    chk(busy === 1'b0, "R2 busy low in outcome cycle", busy, 0);
    chk(res != 3, "R9 done and fail together", res, 1);
  endtask

  task automatic finish_pulse();
    @(negedge clk);
    chk(!done && !fail, "R9 single-cycle outcome", int'(done) + int'(fail), 0);
  endtask

  task automatic run_case(input string req, input int tog, input int errf,
                          input int exp_res, input int exp_reads, input int exp_wr);
    int res;
    setup(tog, errf);
    kick(16'h1000 + 16'(tog));
    wait_end(res);
    chk(res == exp_res, {req, " outcome (1=done 2=fail)"}, res, exp_res);
    chk(rd_cnt == exp_reads, {req, " read count"}, rd_cnt, exp_reads);
    chk(wr_cnt == exp_wr, {req, " reset writes"}, wr_cnt, exp_wr);
    chk(oe_falls == rd_cnt, "R3 oe_n released between reads", oe_falls, rd_cnt);
    if (exp_wr > 0) chk(last_wr == 8'hF0, "R8 reset command word", int'(last_wr), 'hF0);
    finish_pulse();
  endtask

  task automatic t_reset();
    chk(!busy && !done && !fail && !rd_req && !wr_req, "R1 outputs low", int'(busy), 0);
    chk(cs_n && oe_n && we_n, "R1 strobes high", int'({cs_n, oe_n, we_n}), 7);
  endtask

  task automatic t_ignored_start();
    int res;
    setup(4, 1000000);
    kick(16'hA5A5);
    repeat (3) @(negedge clk);
    start = 1; poll_addr = 16'h5A5A;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    chk(dev_addr == 16'hA5A5, "R2 start while busy ignored (addr)", int'(dev_addr), 'hA5A5);
    wait_end(res);
    chk(res == 1 && rd_cnt == 6, "R2 start while busy ignored (reads)", rd_cnt, 6);
    finish_pulse();
    chk(!busy, "R2 no restart from ignored start", busy, 0);
  endtask

  task automatic t_start_on_done();
    int res;
    setup(0, 1000000);
    kick(16'h0111);
    wait_end(res);
    chk(res == 1, "R10 first search done", res, 1);
    start = 1; poll_addr = 16'h0222; rd_cnt = 0;
    @(negedge clk);
    start = 0;
    chk(busy === 1'b1, "R10 start in outcome cycle accepted", busy, 1);
    chk(dev_addr == 16'h0222, "R10 new address latched", int'(dev_addr), 'h222);
    wait_end(res);
    chk(res == 1 && rd_cnt == 2, "R10 second search completes", rd_cnt, 2);
    finish_pulse();
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    run_case("R4 immediate completion", 0, 1000000, 1, 2, 0);
    run_case("R5 toggles then steady", 5, 1000000, 1, 7, 0);
    run_case("R7 limit minus one ends done", MAXP - 1, 1000000, 1, MAXP + 1, 0);
    run_case("R7 limit reached fails", MAXP, 1000000, 2, MAXP + 1, 1);
    run_case("R6 timeout flag, still toggling", 100000, 3, 2, 6, 1);
    run_case("R6 timeout flag, then steady", 3, 3, 1, 6, 0);
    run_case("R7 flag precedence at limit", 100000, MAXP, 2, MAXP + 3, 1);
    t_ignored_start();
    t_start_on_done();
    chk(addr_viol == 0, "R3 address/strobe discipline", addr_viol, 0);
    chk(wr_strobe_bad == 0, "R8 write strobes", wr_strobe_bad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule